// File: doc/BRIEF.md
# Pipelined RAM-Emulated Ternary Match Unit

This block searches a small table of ternary words (each bit 0, 1 or don't-care) and reports the highest-priority stored word that matches an incoming key. It contains no per-bit comparators. The key is cut into equal slices of `SEG_W` bits, and each slice is the read address of its own small RAM. RAM `i` holds, at address `a`, a `WORDS`-bit column vector. Bit `j` of that vector is set exactly when stored word `j` accepts the value `a` in key slice `i`. The unit ANDs the vectors returned by all RAMs, starting from all ones, to get a match vector. A priority encoder then selects the lowest set bit.

The RAMs are spread over `STAGES` pipeline stages. Each stage folds the outputs of its own RAMs into the vector carried from the stage before it. A final stage encodes the result and merges it with the result arriving from an upstream unit. Key, hit flag and index travel along the pipeline, so many units can be chained, each accepting one key per clock. The index produced is global: a per-instance base offset plus the local word number. An upstream hit always beats a local one. An external update engine owns the RAM write ports. It rewrites whole column words while it holds `upd_busy` high, and no lookup is taken during that time.

Top module: `tmatch_unit`

## Requirements
- R1: Key slice `i` is key bits `[i*SEG_W +: SEG_W]`, with slice 0 the least significant, and it addresses RAM `i`. Local word `j` matches when bit `j` is set in the word that every RAM returns for its slice.
- R2: After reset every RAM word is zero, `out_valid` is low, and any lookup reports no hit until words are written.
- R3: When several local words match, the one with the lowest local index is reported.
- R4: A local hit reports `out_idx = BASE_IDX + j`, where `j` is the winning local word.
- R5: A lookup that arrives with `in_hit` high leaves with `out_hit` high and `out_idx` equal to its `in_idx`, whatever the local table holds.
- R6: With no upstream hit and no local match, `out_hit` is 0 and `out_idx` is 0.
- R7: A key accepted at a clock edge appears on `out_key`, with its result and `out_valid` high, `STAGES+1` edges later. Keys on consecutive cycles give results on consecutive cycles.
- R8: While `upd_busy` is high, `in_valid` is ignored and every lookup in flight is dropped. `out_valid` is low at every edge that follows an edge sampled with `upd_busy` high.
- R9: On an edge with `wr_en[i]` high, RAM `i` word `wr_addr` takes `wr_data`. Clearing a word's bit in a column vector deletes that word for that slice value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A key is presented this cycle |
| in_key | input | KEY_W | Search key |
| in_hit | input | 1 | Upstream unit already found a match |
| in_idx | input | IDX_W | Upstream match index |
| upd_busy | input | 1 | Update in progress; lookups blocked |
| wr_en | input | P | Per-RAM write enable |
| wr_addr | input | SEG_W | Write address shared by all RAMs |
| wr_data | input | WORDS | Column vector to store |
| out_valid | output | 1 | Result below is meaningful |
| out_key | output | KEY_W | Key forwarded to the next unit |
| out_hit | output | 1 | Upstream or local match found |
| out_idx | output | IDX_W | Global index of the winning word |

## Verification
The checks assume the update engine writes only while `upd_busy` is high. One assertion states this directly, and the bench raises `upd_busy` one cycle before its first write and drops it one cycle after its last. The checks on index ranges assume that `BASE_IDX + WORDS` fits in `IDX_W` bits, which the default parameters satisfy. Upstream inputs are treated as meaningful only alongside `in_valid`. The bench drives `in_hit` and `in_idx` only together with a presented key.

// File: rtl/tmu_pkg.sv
package tmu_pkg;
  // Defaults shared by the unit and its bench
  localparam int unsigned DEF_KEY_W  = 8;
  localparam int unsigned DEF_SEG_W  = 2;
  localparam int unsigned DEF_WORDS  = 8;
  localparam int unsigned DEF_STAGES = 2;
  localparam int unsigned DEF_IDX_W  = 8;
  localparam int unsigned DEF_BASE   = 16;

  function automatic int unsigned slice_count(int unsigned key_w, int unsigned seg_w);
    return key_w / seg_w;
  endfunction
endpackage

// File: rtl/tmu_seg_ram.sv
module tmu_seg_ram #(
  parameter int unsigned SEG_W = 2,
  parameter int unsigned WORDS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SEG_W-1:0] waddr,
  input  logic [WORDS-1:0] wdata,
  input  logic [SEG_W-1:0] raddr,
  output logic [WORDS-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << SEG_W;

  logic [WORDS-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < DEPTH; a++) mem_q[a] <= '0;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/tmu_and_stage.sv
module tmu_and_stage #(
  parameter int unsigned KEY_W = 8,
  parameter int unsigned SEG_W = 2,
  parameter int unsigned WORDS = 8,
  parameter int unsigned IDX_W = 8,
  parameter int unsigned FIRST = 0,
  parameter int unsigned NRAM  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             v_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic [WORDS-1:0] vec_i,
  input  logic             hit_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [NRAM-1:0]  wr_en,
  input  logic [SEG_W-1:0] wr_addr,
  input  logic [WORDS-1:0] wr_data,
  output logic             v_o,
  output logic [KEY_W-1:0] key_o,
  output logic [WORDS-1:0] vec_o,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [WORDS-1:0] col [NRAM];
  logic [WORDS-1:0] vec_n;
  logic             v_n;
  logic             load_en;

  for (genvar r = 0; r < NRAM; r++) begin : g_ram
    tmu_seg_ram #(.SEG_W(SEG_W), .WORDS(WORDS)) u_ram (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_en[r]),
      .waddr (wr_addr),
      .wdata (wr_data),
      .raddr (key_i[(FIRST+r)*SEG_W +: SEG_W]),
      .rdata (col[r])
    );
  end

  always_comb begin
    vec_n = vec_i;
    for (int r = 0; r < NRAM; r++) vec_n = vec_n & col[r];
    v_n     = v_i & ~flush;
    load_en = v_i & ~flush;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o   <= 1'b0;
      key_o <= '0;
      vec_o <= '0;
      hit_o <= 1'b0;
      idx_o <= '0;
    end else begin
      v_o <= v_n;
      if (load_en) begin
        key_o <= key_i;
        vec_o <= vec_n;
        hit_o <= hit_i;
        idx_o <= idx_i;
      end
    end
  end

  // R8
  stage_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v_o |-> $past(v_i && !flush));

  // R1
  vec_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v_o |-> ((vec_o & ~$past(vec_i)) == '0));
endmodule

// File: rtl/tmu_prio_merge.sv
module tmu_prio_merge #(
  parameter int unsigned KEY_W    = 8,
  parameter int unsigned WORDS    = 8,
  parameter int unsigned IDX_W    = 8,
  parameter int unsigned BASE_IDX = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             v_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic [WORDS-1:0] vec_i,
  input  logic             hit_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             v_o,
  output logic [KEY_W-1:0] key_o,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  logic             loc_any;
  logic [IDX_W-1:0] loc_idx;
  logic             hit_n;
  logic [IDX_W-1:0] idx_n;
  logic             load_en;

  always_comb begin
    loc_any = |vec_i;
    loc_idx = '0;
    for (int j = WORDS - 1; j >= 0; j--) begin
      if (vec_i[j]) loc_idx = IDX_W'(j);
    end
    if (hit_i) begin
      hit_n = 1'b1;
      idx_n = idx_i;
    end else if (loc_any) begin
      hit_n = 1'b1;
      idx_n = IDX_W'(BASE_IDX) + loc_idx;
    end else begin
      hit_n = 1'b0;
      idx_n = '0;
    end
    load_en = v_i & ~flush;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o   <= 1'b0;
      key_o <= '0;
      hit_o <= 1'b0;
      idx_o <= '0;
    end else begin
      v_o <= v_i & ~flush;
      if (load_en) begin
        key_o <= key_i;
        hit_o <= hit_n;
        idx_o <= idx_n;
      end
    end
  end

  // R5
  upstream_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v_o && $past(hit_i)) |-> (hit_o && idx_o == $past(idx_i)));

  // R4
  local_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v_o && hit_o && !$past(hit_i)) |->
      (idx_o >= IDX_W'(BASE_IDX) && idx_o < IDX_W'(BASE_IDX + WORDS)));

  // R6
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v_o && !hit_o) |-> (idx_o == '0));
endmodule

// File: rtl/tmatch_unit.sv
module tmatch_unit
  import tmu_pkg::*;
#(
  parameter int unsigned KEY_W    = DEF_KEY_W,
  parameter int unsigned SEG_W    = DEF_SEG_W,
  parameter int unsigned WORDS    = DEF_WORDS,
  parameter int unsigned STAGES   = DEF_STAGES,
  parameter int unsigned IDX_W    = DEF_IDX_W,
  parameter int unsigned BASE_IDX = DEF_BASE,
  localparam int unsigned P       = slice_count(KEY_W, SEG_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [KEY_W-1:0] in_key,
  input  logic             in_hit,
  input  logic [IDX_W-1:0] in_idx,
  input  logic             upd_busy,
  input  logic [P-1:0]     wr_en,
  input  logic [SEG_W-1:0] wr_addr,
  input  logic [WORDS-1:0] wr_data,
  output logic             out_valid,
  output logic [KEY_W-1:0] out_key,
  output logic             out_hit,
  output logic [IDX_W-1:0] out_idx
);
  // RAMs per stage; P must be a multiple of STAGES
  localparam int unsigned RPS = P / STAGES;

  logic             s_v   [STAGES+1];
  logic [KEY_W-1:0] s_key [STAGES+1];
  logic [WORDS-1:0] s_vec [STAGES+1];
  logic             s_hit [STAGES+1];
  logic [IDX_W-1:0] s_idx [STAGES+1];

  assign s_v[0]   = in_valid;
  assign s_key[0] = in_key;
  assign s_vec[0] = '1;
  assign s_hit[0] = in_hit;
  assign s_idx[0] = in_idx;

  for (genvar h = 0; h < STAGES; h++) begin : g_stage
    tmu_and_stage #(
      .KEY_W(KEY_W), .SEG_W(SEG_W), .WORDS(WORDS), .IDX_W(IDX_W),
      .FIRST(h * RPS), .NRAM(RPS)
    ) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (upd_busy),
      .v_i     (s_v[h]),
      .key_i   (s_key[h]),
      .vec_i   (s_vec[h]),
      .hit_i   (s_hit[h]),
      .idx_i   (s_idx[h]),
      .wr_en   (wr_en[h*RPS +: RPS]),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .v_o     (s_v[h+1]),
      .key_o   (s_key[h+1]),
      .vec_o   (s_vec[h+1]),
      .hit_o   (s_hit[h+1]),
      .idx_o   (s_idx[h+1])
    );
  end

  tmu_prio_merge #(
    .KEY_W(KEY_W), .WORDS(WORDS), .IDX_W(IDX_W), .BASE_IDX(BASE_IDX)
  ) u_prio (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (upd_busy),
    .v_i   (s_v[STAGES]),
    .key_i (s_key[STAGES]),
    .vec_i (s_vec[STAGES]),
    .hit_i (s_hit[STAGES]),
    .idx_i (s_idx[STAGES]),
    .v_o   (out_valid),
    .key_o (out_key),
    .hit_o (out_hit),
    .idx_o (out_idx)
  );

  // R9
  wr_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_en) |-> upd_busy);

  // R8
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_busy |=> !out_valid);
endmodule

// File: tb/tmatch_unit_tb_top.sv
module tmatch_unit_tb_top;
  import tmu_pkg::*;

  localparam int KW    = DEF_KEY_W;
  localparam int SW    = DEF_SEG_W;
  localparam int NW    = DEF_WORDS;
  localparam int NS    = DEF_STAGES;
  localparam int IW    = DEF_IDX_W;
  localparam int BASE  = DEF_BASE;
  localparam int NP    = KW / SW;
  localparam int DEPTH = 1 << SW;
  localparam int LAT   = NS + 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid, in_hit, upd_busy;
  logic [KW-1:0] in_key;
  logic [IW-1:0] in_idx;
  logic [NP-1:0] wr_en;
  logic [SW-1:0] wr_addr;
  logic [NW-1:0] wr_data;
  logic          out_valid, out_hit;
  logic [KW-1:0] out_key;
  logic [IW-1:0] out_idx;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [KW-1:0] wdat [NW];
  logic [KW-1:0] wmsk [NW];
  bit            wlive[NW];
  logic [NW-1:0] shadow [NP][DEPTH];

  always #10 clk = ~clk;

  tmatch_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_key(in_key),
    .in_hit(in_hit), .in_idx(in_idx), .upd_busy(upd_busy), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .out_valid(out_valid),
    .out_key(out_key), .out_hit(out_hit), .out_idx(out_idx)
  );

  task automatic chk(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic void model(logic [KW-1:0] key, bit uh, int ui,
                                output bit hit, output int idx);
    hit = uh;
    idx = uh ? ui : 0;
    if (!uh) begin
      for (int j = NW - 1; j >= 0; j--) begin
        if (wlive[j] && (((key ^ wdat[j]) & wmsk[j]) == '0)) begin
          hit = 1;
          idx = BASE + j;
        end
      end
    end
  endfunction

  // Rewrite every column touched by word j; all tasks start and end just after a negedge
  task automatic write_word(int j);
    upd_busy = 1'b1;
    @(negedge clk);
    for (int r = 0; r < NP; r++) begin
      for (int a = 0; a < DEPTH; a++) begin
        logic [SW-1:0] ds = wdat[j][r*SW +: SW];
        logic [SW-1:0] ms = wmsk[j][r*SW +: SW];
        shadow[r][a][j] = wlive[j] && (((SW'(a) ^ ds) & ms) == '0);
        wr_en   = NP'(1) << r;
        wr_addr = SW'(a);
        wr_data = shadow[r][a];
        @(negedge clk);
      end
    end
    wr_en = '0;
    @(negedge clk);
    upd_busy = 1'b0;
    @(negedge clk);
  endtask

  task automatic add_word(int j, logic [KW-1:0] d, logic [KW-1:0] m);
    wdat[j] = d; wmsk[j] = m; wlive[j] = 1;
    write_word(j);
  endtask

  task automatic del_word(int j);
    wlive[j] = 0;
    write_word(j);
  endtask

  task automatic lookup(string req, logic [KW-1:0] key, bit uh, int ui);
    bit eh; int ei;
    model(key, uh, ui, eh, ei);
    in_valid = 1'b1; in_key = key; in_hit = uh; in_idx = IW'(ui);
    @(negedge clk);
    in_valid = 1'b0; in_hit = 1'b0; in_idx = '0;
    repeat (LAT - 1) @(negedge clk);
    chk(req, "out_valid", int'(out_valid), 1);
    chk(req, "out_hit", int'(out_hit), int'(eh));
    chk(req, "out_idx", int'(out_idx), ei);
  endtask

  // R7: back-to-back keys, results one per cycle with key forwarded
  task automatic stream_test();
    logic [KW-1:0] keys [5] = '{8'hA5, 8'hA7, 8'hC3, 8'h30, 8'hA1};
    for (int c = 0; c < 5 + LAT; c++) begin
      if (c >= LAT) begin
        bit eh; int ei;
        model(keys[c-LAT], 0, 0, eh, ei);
        chk("R7", "stream out_valid", int'(out_valid), 1);
        chk("R7", "stream out_key", int'(out_key), int'(keys[c-LAT]));
        chk("R7", "stream out_idx", int'(out_idx), ei);
        chk("R7", "stream out_hit", int'(out_hit), int'(eh));
      end
      if (c < 5) begin
        in_valid = 1'b1; in_key = keys[c];
      end else begin
        in_valid = 1'b0;
      end
      @(negedge clk);
    end
  endtask

  // R8: busy drops in-flight and ignores new keys
  task automatic busy_test();
    in_valid = 1'b1; in_key = 8'hA5;
    @(negedge clk);
    upd_busy = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8", "in-flight dropped", int'(out_valid), 0);
    upd_busy = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    chk("R8", "busy key ignored", int'(out_valid), 0);
    repeat (2) @(negedge clk);
    chk("R8", "pipeline empty after busy", int'(out_valid), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int j = 0; j < NW; j++) begin
      wdat[j] = '0; wmsk[j] = '0; wlive[j] = 0;
    end
    for (int r = 0; r < NP; r++)
      for (int a = 0; a < DEPTH; a++) shadow[r][a] = '0;
    rst_n = 1'b0; in_valid = 1'b0; in_key = '0; in_hit = 1'b0; in_idx = '0;
    upd_busy = 1'b0; wr_en = '0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    chk("R2", "out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2", "out_valid after reset", int'(out_valid), 0);
    lookup("R2", 8'hA5, 0, 0);             // empty table: no hit, idx 0 (R6)
    lookup("R6", 8'h00, 0, 0);

    add_word(2, 8'hA0, 8'hF0);             // R9 write, R1 high slices only
    lookup("R4", 8'hA7, 0, 0);             // expects BASE+2
    lookup("R1", 8'hB7, 0, 0);             // slice 2 differs: miss
    add_word(0, 8'hA5, 8'hFF);
    lookup("R3", 8'hA5, 0, 0);             // words 0 and 2 hit: 0 wins
    lookup("R3", 8'hA6, 0, 0);             // only word 2
    add_word(5, 8'h00, 8'h00);             // all don't-care
    lookup("R3", 8'h33, 0, 0);             // only word 5
    lookup("R5", 8'hA5, 1, 3);             // upstream index passes through
    lookup("R5", 8'h33, 1, 200);
    del_word(0);
    lookup("R9", 8'hA5, 0, 0);             // word 0 removed: word 2 wins
    del_word(5);
    add_word(7, 8'h03, 8'h03);             // low slice only
    lookup("R1", 8'hC3, 0, 0);             // expects BASE+7
    lookup("R1", 8'h30, 0, 0);             // miss
    lookup("R6", 8'h31, 0, 0);
    stream_test();
    busy_test();
    lookup("R8", 8'hC3, 0, 0);             // normal service resumes

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule